// File: doc/BRIEF.md
# Mailbox Endpoint with Threshold Interrupts

This block is one endpoint of a message channel between two processors. Its local processor reaches it through a 32-bit register window driven by single-cycle read and write strobes. Words written to the push register enter an outbound queue, which drains toward the partner through a valid/ready stream. Words that arrive from the partner on a second valid/ready stream fill an inbound queue, and the local processor pops that queue by reading the pop register.

Two programmable levels watch the queue occupancies. The outbound condition is true while the outbound queue holds no more words than its level, so software can refill it before it runs dry. The inbound condition is true once the inbound queue holds more words than its level, so software can read in bursts. Pushing into a full outbound queue and popping an empty inbound queue are both recorded as sticky errors. The two level conditions and the error events feed a small interrupt unit. Its status bits latch events and are cleared by writing ones, a mask gates them, and the masked bits combine into one interrupt line.

Top module: `mbox_port`

## Requirements
- R1: A write to offset 0x00 while the outbound queue is not full appends the write data. `tx_valid` is high exactly while the outbound queue holds a word, and words leave on `tx_data` in write order, one per cycle with `tx_valid` and `tx_ready` both high.
- R2: `rx_ready` is high while the inbound queue is not full. A word on `rx_data` is stored on each cycle with `rx_valid` and `rx_ready` high. A read of offset 0x08 returns the oldest stored word and removes it. On an empty queue that read returns zero and changes nothing.
- R3: A read of offset 0x10 returns status. Bit 0 is 1 when the inbound queue is empty and bit 1 is 1 when the outbound queue is full.
- R4: Status bit 2 is 1 when the outbound occupancy is less than or equal to the outbound level (offset 0x18, read/write, low bits hold the level).
- R5: Status bit 3 is 1 when the inbound occupancy is strictly greater than the inbound level (offset 0x1C, read/write).
- R6: Offset 0x14 is an error register. Bit 0 is set by a pop of an empty inbound queue and bit 1 by a push into a full outbound queue. Both bits hold until offset 0x14 is read; that read returns the value held before it clears.
- R7: A push into a full outbound queue is discarded. The queue keeps its contents and order.
- R8: Interrupt status (offset 0x20) uses bit 0 for the outbound level, bit 1 for the inbound level and bit 2 for errors. Bits 0 and 1 are set when their status condition goes from 0 to 1. Bit 2 is set on every error event. Writing 1 to a bit clears it.
- R9: Offset 0x24 is the interrupt mask, using the same bit layout. A read of offset 0x28 returns interrupt status AND mask, and writes to 0x28 have no effect. `irq` is high when any of those bits is 1.
- R10: After reset both queues are empty, both levels, the mask, the interrupt status and the error register are zero, and status reads 0x5.
- R11: When a push and a pop hit the same queue in the same cycle, its occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle of `reg_rd`, zero otherwise |
| tx_valid | output | 1 | Outbound word available |
| tx_ready | input | 1 | Partner accepts the outbound word |
| tx_data | output | DATA_W | Oldest outbound word |
| rx_valid | input | 1 | Inbound word offered |
| rx_ready | output | 1 | Inbound queue has room |
| rx_data | input | DATA_W | Inbound word |
| irq | output | 1 | OR of the masked interrupt status bits |

## Verification
Some properties are checked on every cycle. `tx_valid` and `rx_ready` must agree with the queue occupancies. Status reads must report the full flag and the outbound level comparison correctly. A pop of an empty queue must return zero, and a combined push and pop must leave occupancy unchanged. Error bits must hold until they are read and must be zero after that read, and `irq` must agree with a read of the pending register. The edge behaviour of the interrupt status bits needs scenarios, because an interrupt status bit must not set again while its condition stays true. The same holds for in-order delivery across both streams, for the strict and non-strict level boundaries, and for the mask's effect on `irq`.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int REG_AW = 6;

    localparam logic [REG_AW-1:0] OFF_PUSH = 6'h00;
    localparam logic [REG_AW-1:0] OFF_POP  = 6'h08;
    localparam logic [REG_AW-1:0] OFF_STAT = 6'h10;
    localparam logic [REG_AW-1:0] OFF_ERR  = 6'h14;
    localparam logic [REG_AW-1:0] OFF_TLVL = 6'h18;
    localparam logic [REG_AW-1:0] OFF_RLVL = 6'h1C;
    localparam logic [REG_AW-1:0] OFF_ISR  = 6'h20;
    localparam logic [REG_AW-1:0] OFF_MASK = 6'h24;
    localparam logic [REG_AW-1:0] OFF_PEND = 6'h28;

    localparam int IRQ_N = 3;

    // bit 0 inbound empty, bit 1 outbound full, bit 2 outbound level, bit 3 inbound level
    typedef struct packed {
        logic rx_lvl;
        logic tx_lvl;
        logic tx_full;
        logic rx_empty;
    } stat_t;

    // bit 0 pop on empty, bit 1 push on full
    typedef struct packed {
        logic push_full;
        logic pop_empty;
    } err_t;

    // bit 0 outbound level, bit 1 inbound level, bit 2 error
    typedef struct packed {
        logic err;
        logic rx_lvl;
        logic tx_lvl;
    } irq_vec_t;

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t             st_d, st_q;
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign full  = (st_q.cnt == CNT_W'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign count = st_q.cnt;
    assign head  = mem_q[st_q.rd];

    always_comb begin
        st_d    = st_q;
        mem_d   = mem_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            mem_d[st_q.wr] = wdata;
            st_d.wr        = step(st_q.wr);
        end
        if (do_pop) begin
            st_d.rd = step(st_q.rd);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

endmodule

// File: rtl/mbox_cfg.sv
module mbox_cfg
    import mbox_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] lvl_in,
    input  logic [IRQ_N-1:0] mask_in,
    input  logic             wr_tlvl,
    input  logic             wr_rlvl,
    input  logic             wr_mask,
    input  logic             rd_err,
    input  logic             ev_pop_empty,
    input  logic             ev_push_full,
    output logic [CNT_W-1:0] tlvl,
    output logic [CNT_W-1:0] rlvl,
    output logic [IRQ_N-1:0] mask,
    output err_t             err
);

    typedef struct packed {
        logic [CNT_W-1:0] tlvl;
        logic [CNT_W-1:0] rlvl;
        logic [IRQ_N-1:0] mask;
        err_t             err;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_tlvl) st_d.tlvl = lvl_in;
        if (wr_rlvl) st_d.rlvl = lvl_in;
        if (wr_mask) st_d.mask = mask_in;
        if (rd_err)  st_d.err  = '0;
        st_d.err.pop_empty = st_d.err.pop_empty | ev_pop_empty;
        st_d.err.push_full = st_d.err.push_full | ev_push_full;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tlvl = st_q.tlvl;
    assign rlvl = st_q.rlvl;
    assign mask = st_q.mask;
    assign err  = st_q.err;

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_lvl,
    input  logic             rx_lvl,
    input  logic             err_evt,
    input  logic             clr_en,
    input  logic [IRQ_N-1:0] clr_bits,
    output irq_vec_t         isr
);

    typedef struct packed {
        irq_vec_t isr;
        logic     tx_prev;
        logic     rx_prev;
    } irq_st_t;

    irq_st_t  st_d, st_q;
    irq_vec_t set_v;
    irq_vec_t clr_v;

    always_comb begin
        set_v.tx_lvl = tx_lvl && !st_q.tx_prev;
        set_v.rx_lvl = rx_lvl && !st_q.rx_prev;
        set_v.err    = err_evt;
        clr_v        = clr_en ? irq_vec_t'(clr_bits) : irq_vec_t'('0);
        st_d         = st_q;
        st_d.isr     = (st_q.isr & ~clr_v) | set_v;
        st_d.tx_prev = tx_lvl;
        st_d.rx_prev = rx_lvl;
    end

    // the outbound condition is true out of reset (empty queue, level zero)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.isr     <= '0;
            st_q.tx_prev <= 1'b1;
            st_q.rx_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign isr = st_q.isr;

endmodule

// File: rtl/mbox_port.sv
module mbox_port
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DATA_W-1:0] tx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DATA_W-1:0] rx_data,
    output logic              irq
);

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  tlvl, rlvl;
    logic [IRQ_N-1:0]  mask;
    err_t              err;
    irq_vec_t          isr;
    stat_t             stat;
    logic [IRQ_N-1:0]  pend;
    logic              hit_push, hit_pop, ev_pop_empty, ev_push_full;
    logic [DATA_W-1:0] rd_mux;

    assign hit_push     = reg_wr && (reg_addr == OFF_PUSH);
    assign hit_pop      = reg_rd && (reg_addr == OFF_POP);
    assign ev_push_full = hit_push && tx_full;
    assign ev_pop_empty = hit_pop && rx_empty;

    mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hit_push),
        .pop   (tx_valid && tx_ready),
        .wdata (reg_wdata),
        .head  (tx_data),
        .count (tx_cnt),
        .full  (tx_full),
        .empty (tx_empty)
    );

    mbox_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_valid),
        .pop   (hit_pop),
        .wdata (rx_data),
        .head  (rx_head),
        .count (rx_cnt),
        .full  (rx_full),
        .empty (rx_empty)
    );

    assign tx_valid = !tx_empty;
    assign rx_ready = !rx_full;

    mbox_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .lvl_in       (reg_wdata[CNT_W-1:0]),
        .mask_in      (reg_wdata[IRQ_N-1:0]),
        .wr_tlvl      (reg_wr && (reg_addr == OFF_TLVL)),
        .wr_rlvl      (reg_wr && (reg_addr == OFF_RLVL)),
        .wr_mask      (reg_wr && (reg_addr == OFF_MASK)),
        .rd_err       (reg_rd && (reg_addr == OFF_ERR)),
        .ev_pop_empty (ev_pop_empty),
        .ev_push_full (ev_push_full),
        .tlvl         (tlvl),
        .rlvl         (rlvl),
        .mask         (mask),
        .err          (err)
    );

    always_comb begin
        stat.rx_empty = rx_empty;
        stat.tx_full  = tx_full;
        stat.tx_lvl   = (tx_cnt <= tlvl);
        stat.rx_lvl   = (rx_cnt > rlvl);
    end

    mbox_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_lvl   (stat.tx_lvl),
        .rx_lvl   (stat.rx_lvl),
        .err_evt  (ev_pop_empty || ev_push_full),
        .clr_en   (reg_wr && (reg_addr == OFF_ISR)),
        .clr_bits (reg_wdata[IRQ_N-1:0]),
        .isr      (isr)
    );

    assign pend = isr & mask;
    assign irq  = |pend;

    always_comb begin
        case (reg_addr)
            OFF_POP:  rd_mux = rx_empty ? '0 : rx_head;
            OFF_STAT: rd_mux = DATA_W'(stat);
            OFF_ERR:  rd_mux = DATA_W'(err);
            OFF_TLVL: rd_mux = DATA_W'(tlvl);
            OFF_RLVL: rd_mux = DATA_W'(rlvl);
            OFF_ISR:  rd_mux = DATA_W'(isr);
            OFF_MASK: rd_mux = DATA_W'(mask);
            OFF_PEND: rd_mux = DATA_W'(pend);
            default:  rd_mux = '0;
        endcase
        reg_rdata = reg_rd ? rd_mux : '0;
    end

endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk
    import mbox_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rx_ready,
    input logic              irq,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [CNT_W-1:0]  rx_cnt,
    input logic [CNT_W-1:0]  tlvl,
    input err_t              err
);

    assert_tx_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid == (tx_cnt != '0));

    assert_rx_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready == (rx_cnt != CNT_W'(DEPTH)));

    assert_empty_pop_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_POP && rx_cnt == '0) |-> (reg_rdata == '0));

    assert_full_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_STAT) |-> (reg_rdata[1] == (tx_cnt == CNT_W'(DEPTH))));

    assert_tx_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_STAT) |-> (reg_rdata[2] == (tx_cnt <= tlvl)));

    assert_err_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err.pop_empty && !(reg_rd && reg_addr == OFF_ERR)) |=> err.pop_empty);

    assert_err_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_ERR) |=> (err == '0));

    assert_drop_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_PUSH && tx_cnt == CNT_W'(DEPTH) && !tx_ready)
        |=> $stable(tx_cnt));

    assert_pend_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFF_PEND) |-> ((reg_rdata[IRQ_N-1:0] != '0) == irq));

    assert_both_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_PUSH && tx_cnt != CNT_W'(DEPTH) && tx_valid && tx_ready)
        |=> $stable(tx_cnt));

endmodule

bind mbox_port mbox_port_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_ready  (rx_ready),
    .irq       (irq),
    .tx_cnt    (tx_cnt),
    .rx_cnt    (rx_cnt),
    .tlvl      (tlvl),
    .err       (err)
);

// File: tb/sim_mbox_port.sv
module sim_mbox_port;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 32;
    localparam int DEPTH      = 4;
    localparam int NVEC       = 30;
    localparam logic RD = 1'b1;
    localparam logic WR = 1'b0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          tx_valid;
    logic          tx_ready = 1'b0;
    logic [DW-1:0] tx_data;
    logic          rx_valid = 1'b0;
    logic          rx_ready;
    logic [DW-1:0] rx_data = '0;
    logic          irq;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mbox_port #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tx_valid  (tx_valid),
        .tx_ready  (tx_ready),
        .tx_data   (tx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .rx_data   (rx_data),
        .irq       (irq)
    );

    // {read, offset, write data or expected read data}; tags per row in comments
    localparam logic [38:0] VEC [NVEC] = '{
        {RD, 6'h10, 32'h5},   // R10 R3 R4 status after reset
        {RD, 6'h14, 32'h0},   // R10
        {RD, 6'h18, 32'h0},   // R10
        {RD, 6'h1C, 32'h0},   // R10
        {RD, 6'h24, 32'h0},   // R10
        {RD, 6'h20, 32'h0},   // R10
        {WR, 6'h00, 32'hA1},  // R1
        {RD, 6'h10, 32'h1},   // R4 one word over level zero
        {WR, 6'h18, 32'h2},
        {RD, 6'h10, 32'h5},   // R4 1 <= 2
        {RD, 6'h20, 32'h1},   // R8 rise of outbound level
        {WR, 6'h20, 32'h1},   // R8 clear
        {RD, 6'h20, 32'h0},   // R8
        {WR, 6'h00, 32'hA2},
        {WR, 6'h00, 32'hA3},
        {WR, 6'h00, 32'hA4},
        {RD, 6'h10, 32'h3},   // R3 full
        {WR, 6'h00, 32'hA5},  // R7 dropped
        {RD, 6'h14, 32'h2},   // R6 push-full bit
        {RD, 6'h14, 32'h0},   // R6 cleared by read
        {RD, 6'h20, 32'h4},   // R8 error bit
        {RD, 6'h08, 32'h0},   // R2 empty pop
        {RD, 6'h14, 32'h1},   // R6 pop-empty bit
        {WR, 6'h24, 32'h4},
        {RD, 6'h28, 32'h4},   // R9
        {WR, 6'h28, 32'h0},   // R9 ignored
        {RD, 6'h28, 32'h4},   // R9
        {WR, 6'h20, 32'h4},
        {RD, 6'h28, 32'h0},   // R9
        {RD, 6'h18, 32'h2}    // R4 level readback
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic rd, input logic [5:0] addr,
                          input logic [DW-1:0] wd, output logic [DW-1:0] rdv);
        @(negedge clk);
        reg_addr  = addr;
        reg_rd    = rd;
        reg_wr    = !rd;
        reg_wdata = wd;
        #1 rdv = reg_rdata;
        @(posedge clk);
        #1;
        reg_rd = 1'b0;
        reg_wr = 1'b0;
    endtask

    task automatic wr(input logic [5:0] addr, input logic [DW-1:0] wd);
        logic [DW-1:0] dummy;
        access(WR, addr, wd, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] addr, input logic [DW-1:0] exp);
        logic [DW-1:0] v;
        access(RD, addr, '0, v);
        check(tag, v, exp);
    endtask

    task automatic rx_push(input logic [DW-1:0] d);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = d;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            access(VEC[i][38], VEC[i][37:32], VEC[i][31:0], v);
            if (VEC[i][38]) check($sformatf("table row %0d", i), v, VEC[i][31:0]);
        end

        // R1: drain the outbound queue in order; R7: A5 never appears
        @(negedge clk);
        tx_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            #1;
            check("R1 tx_valid", DW'(tx_valid), 1);
            check("R1 tx_data order", tx_data, DW'(32'hA1 + i));
            @(posedge clk);
            @(negedge clk);
        end
        #1 check("R1 tx_valid low when empty", DW'(tx_valid), 0);
        tx_ready = 1'b0;
        rd_chk("R8 outbound level rise", 6'h20, 32'h1);
        #1 check("R9 irq masked", DW'(irq), 0);
        wr(6'h24, 32'h1);
        #1 check("R9 irq unmasked", DW'(irq), 1);
        wr(6'h20, 32'h1);
        #1 check("R9 irq after clear", DW'(irq), 0);
        wr(6'h24, 32'h0);

        // R5: strict comparison against inbound level 3; R2 fill and full
        wr(6'h1C, 32'h3);
        for (int i = 0; i < 3; i++) rx_push(DW'(32'hB0 + i));
        rd_chk("R5 three not above three", 6'h10, 32'h4);
        rx_push(32'hB3);
        @(negedge clk);
        #1 check("R2 rx_ready low when full", DW'(rx_ready), 0);
        rx_valid = 1'b1;
        rx_data  = 32'hBF;
        @(posedge clk);
        #1 rx_valid = 1'b0;
        rd_chk("R5 four above three", 6'h10, 32'hC);
        rd_chk("R8 inbound level rise", 6'h20, 32'h2);
        for (int i = 0; i < 4; i++) rd_chk("R2 pop order", 6'h08, DW'(32'hB0 + i));
        rd_chk("R2 pop on empty", 6'h08, 32'h0);
        rd_chk("R6 pop-empty recorded", 6'h14, 32'h1);
        @(negedge clk);
        #1 check("R2 rx_ready after drain", DW'(rx_ready), 1);
        wr(6'h1C, 32'h0);
        wr(6'h20, 32'h7);

        // R11: push and pop on the inbound queue in one cycle
        rx_push(32'hC0);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = 32'hC1;
        reg_addr = 6'h08;
        reg_rd   = 1'b1;
        #1 v = reg_rdata;
        @(posedge clk);
        #1;
        rx_valid = 1'b0;
        reg_rd   = 1'b0;
        check("R11 popped oldest", v, 32'hC0);
        rd_chk("R11 occupancy one", 6'h10, 32'hC);
        rd_chk("R11 newer word", 6'h08, 32'hC1);
        rd_chk("R11 now empty", 6'h10, 32'h5);

        // R10: reset in the middle of a run
        wr(6'h24, 32'h7);
        wr(6'h18, 32'h3);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 check("R10 irq after reset", DW'(irq), 0);
        rd_chk("R10 status after reset", 6'h10, 32'h5);
        rd_chk("R10 mask after reset", 6'h24, 32'h0);
        rd_chk("R10 level after reset", 6'h18, 32'h0);
        rd_chk("R10 isr after reset", 6'h20, 32'h0);

        finish_run();
    end

endmodule